// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide register front end of one eight-line interrupt controller. A host issues single-cycle write and read strobes with a one-bit address and an 8-bit data byte. Writes at the even address either start a new initialization sequence or carry an operation word. Writes at the odd address feed the rest of the initialization sequence, or load the line mask once the controller is running. From these the block keeps the configuration that an attached priority resolver consumes: the line mask, the rotating priority base, the vector base, and the nesting, auto-EOI and special-mask mode flags. It also issues one-cycle clear requests for in-service and request bits.

The request and in-service registers and the priority winner live in the resolver and come back as inputs. The decoder scans the in-service bits itself only to find the line that a non-specific end-of-interrupt clears. A read returns the request or in-service set, the mask, or a one-shot poll byte. A separately selected trigger-mode register stores only the bits allowed by a fixed parameter mask.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset, mask_out, rot_base, vec_base, trig_mode, rdata, all mode flags and all clear pulses are zero, and the sequencer is in its running state.
- R2: An even-address write with data bit 4 set clears mask_out, rot_base, special_mask and the read-select flag. In the next cycle it pulses init_flush and drives req_clr with the inverse of trig_mode. It clears nest_special and auto_eoi only when data bit 0 is 0.
- R3: After an initialization start, the first odd write sets vec_base to data AND 0xF8. The second odd write has no visible effect. A third odd write follows only when the start had bit 0 set: it sets nest_special from data bit 4 and auto_eoi from data bit 1. Until the sequence is over, odd writes leave mask_out unchanged.
- R4: In the running state, an odd-address write loads mask_out with the data byte.
- R5: An even write with bit 4 clear and bit 3 set arms the poll when bit 2 is 1. It loads the read-select flag from bit 0 only when bit 1 is 1, and loads special_mask from bit 5 only when bit 6 is 1.
- R6: An even write with bits 4 and 3 clear and command code (bits 7:5) equal to 0 or 4 sets rot_auto_eoi to bit 2 of the code.
- R7: Code 1 pulses svc_clr for one cycle, on the highest-priority set bit of svc_bits. Priority is scanned from line rot_base upward, modulo 8. Code 5 does the same and also sets rot_base to that line plus one, modulo 8. When svc_bits is zero, both codes leave svc_clr zero and rot_base unchanged.
- R8: Code 3 pulses svc_clr on the line given by data bits 2:0. Code 7 does the same and also sets rot_base to that line plus one, modulo 8.
- R9: Code 6 sets rot_base to data bits 2:0 plus one, modulo 8. Code 2 changes nothing.
- R10: A read while the poll is armed returns 0x80 OR win_line when win_valid is 1, and pulses svc_clr and req_clr on that line. When win_valid is 0 it returns 0x07 with no pulses. Either way the poll disarms.
- R11: Any other read returns svc_bits (read-select 1) or req_bits (read-select 0) from the even address, and mask_out from the odd address. The value appears on rdata in the cycle after the strobe.
- R12: A write with trig_sel set stores data AND WR_MASK (default 0xF8) in trig_mode. A read with trig_sel set returns trig_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| addr | input | 1 | Even (0) or odd (1) controller address |
| trig_sel | input | 1 | Selects the trigger-mode register instead of the controller |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| req_bits | input | 8 | Request bits from the resolver |
| svc_bits | input | 8 | In-service bits from the resolver |
| win_valid | input | 1 | Resolver has a winning line |
| win_line | input | 3 | Winning line number |
| mask_out | output | 8 | Line mask |
| rot_base | output | 3 | Line that currently has the highest priority |
| vec_base | output | 8 | Vector base, low three bits zero |
| trig_mode | output | 8 | Per-line level-trigger flags |
| nest_special | output | 1 | Special nesting mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| rot_auto_eoi | output | 1 | Rotate on automatic end-of-interrupt |
| special_mask | output | 1 | Special mask mode |
| svc_clr | output | 8 | One-cycle in-service clear request |
| req_clr | output | 8 | One-cycle request clear request |
| init_flush | output | 1 | One-cycle pulse on initialization start |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle. They also assume that the resolver inputs stay steady during a strobe. The bench drives only one strobe per task, on the falling edge, and changes req_bits, svc_bits and the winner only between tasks. Under these assumptions each property pins down the effect of one operation, and no other operation in the same cycle can interfere.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

    localparam int LINES  = 8;
    localparam int LINE_W = $clog2(LINES);

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_BASE = 2'd1,
        ST_SKIP = 2'd2,
        ST_MODE = 2'd3
    } seq_state_t;

    typedef enum logic [2:0] {
        CMD_RAE_OFF = 3'd0,
        CMD_EOI_NS  = 3'd1,
        CMD_NOP     = 3'd2,
        CMD_EOI_SP  = 3'd3,
        CMD_RAE_ON  = 3'd4,
        CMD_EOI_ROT = 3'd5,
        CMD_SET_PRI = 3'd6,
        CMD_EOI_SPR = 3'd7
    } cmd_code_t;

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] line;
    } pick_t;

    // first set bit when scanning upward from 'base', wrapping
    function automatic pick_t top_line(input logic [LINES-1:0] bits,
                                       input logic [LINE_W-1:0] base);
        pick_t p;
        p.valid = 1'b0;
        p.line  = '0;
        for (int k = LINES - 1; k >= 0; k--) begin
            logic [LINE_W-1:0] idx;
            idx = base + LINE_W'(k);
            if (bits[idx]) begin
                p.valid = 1'b1;
                p.line  = idx;
            end
        end
        return p;
    endfunction

    function automatic logic [LINES-1:0] line_bit(input logic [LINE_W-1:0] l);
        return LINES'(1) << l;
    endfunction

endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init_start,
    input  logic             odd_wr,
    input  logic [LINES-1:0] wdata,
    output seq_state_t       state,
    output logic [LINES-1:0] vec_base,
    output logic             nest_special,
    output logic             auto_eoi,
    output logic             init_flush,
    output logic             mask_load
);
    localparam logic [LINES-1:0] BASE_KEEP = ~LINES'((1 << LINE_W) - 1);

    logic need_mode;

    assign mask_load = odd_wr && (state == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_RUN;
            need_mode    <= 1'b0;
            vec_base     <= '0;
            nest_special <= 1'b0;
            auto_eoi     <= 1'b0;
            init_flush   <= 1'b0;
        end else begin
            init_flush <= 1'b0;
            if (init_start) begin
                need_mode  <= wdata[0];
                state      <= ST_BASE;
                init_flush <= 1'b1;
                if (!wdata[0]) begin
                    nest_special <= 1'b0;
                    auto_eoi     <= 1'b0;
                end
            end else if (odd_wr) begin
                case (state)
                    ST_BASE: begin
                        vec_base <= wdata & BASE_KEEP;
                        state    <= ST_SKIP;
                    end
                    ST_SKIP: state <= need_mode ? ST_MODE : ST_RUN;
                    ST_MODE: begin
                        nest_special <= wdata[4];
                        auto_eoi     <= wdata[1];
                        state        <= ST_RUN;
                    end
                    default: state <= ST_RUN;
                endcase
            end
        end
    end
endmodule

// File: rtl/pic_ocw_unit.sv
module pic_ocw_unit
    import pic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init_start,
    input  logic              mask_load,
    input  logic              ocw3_wr,
    input  logic              ocw2_wr,
    input  logic              poll_take,
    input  logic [LINES-1:0]  wdata,
    input  logic [LINES-1:0]  svc_bits,
    input  logic [LINES-1:0]  trig_mode,
    input  logic              win_valid,
    input  logic [LINE_W-1:0] win_line,
    output logic [LINES-1:0]  mask_out,
    output logic [LINE_W-1:0] rot_base,
    output logic              special_mask,
    output logic              read_sel,
    output logic              poll_armed,
    output logic              rot_auto_eoi,
    output logic [LINES-1:0]  svc_clr,
    output logic [LINES-1:0]  req_clr
);
    cmd_code_t         code;
    pick_t             ns_pick;
    logic [LINE_W-1:0] named;

    assign code    = cmd_code_t'(wdata[7:5]);
    assign named   = wdata[LINE_W-1:0];
    assign ns_pick = top_line(svc_bits, rot_base);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_out     <= '0;
            rot_base     <= '0;
            special_mask <= 1'b0;
            read_sel     <= 1'b0;
            poll_armed   <= 1'b0;
            rot_auto_eoi <= 1'b0;
            svc_clr      <= '0;
            req_clr      <= '0;
        end else begin
            svc_clr <= '0;
            req_clr <= '0;
            if (init_start) begin
                mask_out     <= '0;
                rot_base     <= '0;
                special_mask <= 1'b0;
                read_sel     <= 1'b0;
                req_clr      <= ~trig_mode;
            end else if (mask_load) begin
                mask_out <= wdata;
            end else if (ocw3_wr) begin
                if (wdata[2]) poll_armed   <= 1'b1;
                if (wdata[1]) read_sel     <= wdata[0];
                if (wdata[6]) special_mask <= wdata[5];
            end else if (ocw2_wr) begin
                case (code)
                    CMD_RAE_OFF, CMD_RAE_ON: rot_auto_eoi <= code[2];
                    CMD_EOI_NS, CMD_EOI_ROT: begin
                        if (ns_pick.valid) begin
                            svc_clr <= line_bit(ns_pick.line);
                            if (code == CMD_EOI_ROT)
                                rot_base <= ns_pick.line + 1'b1;
                        end
                    end
                    CMD_EOI_SP:  svc_clr <= line_bit(named);
                    CMD_SET_PRI: rot_base <= named + 1'b1;
                    CMD_EOI_SPR: begin
                        svc_clr  <= line_bit(named);
                        rot_base <= named + 1'b1;
                    end
                    default: ;
                endcase
            end else if (poll_take) begin
                poll_armed <= 1'b0;
                if (win_valid) begin
                    svc_clr <= line_bit(win_line);
                    req_clr <= line_bit(win_line);
                end
            end
        end
    end
endmodule

// File: rtl/pic_read_port.sv
module pic_read_port
    import pic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              addr,
    input  logic              trig_sel,
    input  logic              poll_armed,
    input  logic              read_sel,
    input  logic              win_valid,
    input  logic [LINE_W-1:0] win_line,
    input  logic [LINES-1:0]  req_bits,
    input  logic [LINES-1:0]  svc_bits,
    input  logic [LINES-1:0]  mask_out,
    input  logic [LINES-1:0]  trig_mode,
    output logic [LINES-1:0]  rdata
);
    localparam logic [LINES-1:0] IDLE_POLL = LINES'(LINES - 1);

    logic [LINES-1:0] poll_byte;

    assign poll_byte = win_valid
        ? {1'b1, {(LINES-1-LINE_W){1'b0}}, win_line}
        : IDLE_POLL;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (trig_sel)        rdata <= trig_mode;
            else if (poll_armed) rdata <= poll_byte;
            else if (addr)       rdata <= mask_out;
            else                 rdata <= read_sel ? svc_bits : req_bits;
        end
    end
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
    import pic_cmd_pkg::*;
#(
    parameter logic [7:0] WR_MASK = 8'hF8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       addr,
    input  logic       trig_sel,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [7:0] req_bits,
    input  logic [7:0] svc_bits,
    input  logic       win_valid,
    input  logic [2:0] win_line,
    output logic [7:0] mask_out,
    output logic [2:0] rot_base,
    output logic [7:0] vec_base,
    output logic [7:0] trig_mode,
    output logic       nest_special,
    output logic       auto_eoi,
    output logic       rot_auto_eoi,
    output logic       special_mask,
    output logic [7:0] svc_clr,
    output logic [7:0] req_clr,
    output logic       init_flush
);
    logic       wr_ctl, init_start, ocw3_wr, ocw2_wr, odd_wr, poll_take;
    logic       mask_load, read_sel, poll_armed;
    seq_state_t seq_st;

    assign wr_ctl     = wr_en && !trig_sel;
    assign init_start = wr_ctl && !addr && wdata[4];
    assign ocw3_wr    = wr_ctl && !addr && !wdata[4] && wdata[3];
    assign ocw2_wr    = wr_ctl && !addr && !wdata[4] && !wdata[3];
    assign odd_wr     = wr_ctl && addr;
    assign poll_take  = rd_en && !trig_sel && poll_armed;

    always_ff @(posedge clk) begin
        if (rst)                   trig_mode <= '0;
        else if (wr_en && trig_sel) trig_mode <= wdata & WR_MASK;
    end

    pic_init_seq u_seq (
        .clk(clk), .rst(rst), .init_start(init_start), .odd_wr(odd_wr),
        .wdata(wdata), .state(seq_st), .vec_base(vec_base),
        .nest_special(nest_special), .auto_eoi(auto_eoi),
        .init_flush(init_flush), .mask_load(mask_load)
    );

    pic_ocw_unit u_ocw (
        .clk(clk), .rst(rst), .init_start(init_start), .mask_load(mask_load),
        .ocw3_wr(ocw3_wr), .ocw2_wr(ocw2_wr), .poll_take(poll_take),
        .wdata(wdata), .svc_bits(svc_bits), .trig_mode(trig_mode),
        .win_valid(win_valid), .win_line(win_line),
        .mask_out(mask_out), .rot_base(rot_base), .special_mask(special_mask),
        .read_sel(read_sel), .poll_armed(poll_armed),
        .rot_auto_eoi(rot_auto_eoi), .svc_clr(svc_clr), .req_clr(req_clr)
    );

    pic_read_port u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .trig_sel(trig_sel),
        .poll_armed(poll_armed), .read_sel(read_sel), .win_valid(win_valid),
        .win_line(win_line), .req_bits(req_bits), .svc_bits(svc_bits),
        .mask_out(mask_out), .trig_mode(trig_mode), .rdata(rdata)
    );
endmodule

// File: rtl/pic_cmd_decoder_chk.sv
module pic_cmd_decoder_chk
    import pic_cmd_pkg::*;
#(
    parameter logic [7:0] WR_MASK = 8'hF8
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic       addr,
    input logic       trig_sel,
    input logic [7:0] wdata,
    input logic [7:0] svc_bits,
    input logic [7:0] mask_out,
    input logic [2:0] rot_base,
    input logic [7:0] trig_mode,
    input logic [7:0] svc_clr,
    input logic       init_flush,
    input logic       poll_armed,
    input logic [1:0] seq_st
);
    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !trig_sel && !addr && wdata[4]) |=>
        (mask_out == 8'h00 && rot_base == 3'd0 && init_flush)); // R2

    AST_MASK_HELD_IN_INIT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !trig_sel && addr && seq_st != 2'd0) |=> $stable(mask_out)); // R3

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !trig_sel && addr && seq_st == 2'd0) |=> (mask_out == $past(wdata))); // R4

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(svc_clr)); // R7

    AST_EMPTY_EOI: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !trig_sel && !addr && wdata[4:3] == 2'b00 &&
         (wdata[7:5] == 3'd1 || wdata[7:5] == 3'd5) && svc_bits == 8'h00)
        |=> (svc_clr == 8'h00 && $stable(rot_base))); // R7

    AST_POLL_ONESHOT: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && !trig_sel && poll_armed) |=> !poll_armed); // R10

    AST_TRIG_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && trig_sel) |=> (trig_mode == ($past(wdata) & WR_MASK))); // R12
endmodule

bind pic_cmd_decoder pic_cmd_decoder_chk #(.WR_MASK(WR_MASK)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .trig_sel(trig_sel), .wdata(wdata), .svc_bits(svc_bits),
    .mask_out(mask_out), .rot_base(rot_base), .trig_mode(trig_mode),
    .svc_clr(svc_clr), .init_flush(init_flush), .poll_armed(poll_armed),
    .seq_st(seq_st)
);

// File: tb/pic_cmd_decoder_test.sv
`timescale 1ns/1ps
module pic_cmd_decoder_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, trig_sel = 1'b0;
    logic [7:0] wdata = '0, req_bits = '0, svc_bits = '0;
    logic       win_valid = 1'b0;
    logic [2:0] win_line = '0;
    logic [7:0] rdata, mask_out, vec_base, trig_mode, svc_clr, req_clr;
    logic [2:0] rot_base;
    logic       nest_special, auto_eoi, rot_auto_eoi, special_mask, init_flush;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pic_cmd_decoder uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .trig_sel(trig_sel), .wdata(wdata), .rdata(rdata),
        .req_bits(req_bits), .svc_bits(svc_bits), .win_valid(win_valid),
        .win_line(win_line), .mask_out(mask_out), .rot_base(rot_base),
        .vec_base(vec_base), .trig_mode(trig_mode),
        .nest_special(nest_special), .auto_eoi(auto_eoi),
        .rot_auto_eoi(rot_auto_eoi), .special_mask(special_mask),
        .svc_clr(svc_clr), .req_clr(req_clr), .init_flush(init_flush)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic a, input logic t, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; trig_sel = t; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; trig_sel = 1'b0;
    endtask

    task automatic rd(input logic a, input logic t);
        @(negedge clk);
        rd_en = 1'b1; addr = a; trig_sel = t;
        @(negedge clk);
        rd_en = 1'b0; trig_sel = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mask", mask_out, 8'h00);
        chk("R1 rot", {5'd0, rot_base}, 8'h00);
        chk("R1 vec", vec_base, 8'h00);
        chk("R1 trig", trig_mode, 8'h00);
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 flags", {nest_special, auto_eoi, rot_auto_eoi, special_mask, init_flush}, 8'h00);
        chk("R1 clr", svc_clr | req_clr, 8'h00);
    endtask

    task automatic t_trig();
        wr(1'b0, 1'b1, 8'hFF);
        chk("R12 trig masked", trig_mode, 8'hF8);
        wr(1'b1, 1'b1, 8'h07);
        chk("R12 low bits dropped", trig_mode, 8'h00);
        chk("R12 no mask side effect", mask_out, 8'h00);
        wr(1'b0, 1'b1, 8'hA9);
        rd(1'b0, 1'b1);
        chk("R12 readback", rdata, 8'hA8);
        wr(1'b0, 1'b1, 8'hF8);
    endtask

    task automatic t_running_setup();
        wr(1'b1, 1'b0, 8'h5A);
        chk("R4 mask load", mask_out, 8'h5A);
        wr(1'b0, 1'b0, 8'hC3);
        chk("R9 set priority", {5'd0, rot_base}, 8'h04);
        wr(1'b0, 1'b0, 8'h68);
        chk("R5 special mask set", {7'd0, special_mask}, 8'h01);
        wr(1'b0, 1'b0, 8'h0B);
    endtask

    task automatic t_init_full();
        req_bits = 8'h3C; svc_bits = 8'hA5;
        wr(1'b0, 1'b0, 8'h11);
        chk("R2 flush pulse", {7'd0, init_flush}, 8'h01);
        chk("R2 edge request clear", req_clr, 8'h07);
        chk("R2 mask cleared", mask_out, 8'h00);
        chk("R2 rot cleared", {5'd0, rot_base}, 8'h00);
        chk("R2 smm cleared", {7'd0, special_mask}, 8'h00);
        @(negedge clk);
        chk("R2 flush one cycle", {7'd0, init_flush}, 8'h00);
        wr(1'b1, 1'b0, 8'h47);
        chk("R3 vector base", vec_base, 8'h40);
        wr(1'b1, 1'b0, 8'h99);
        chk("R3 second word no mask", mask_out, 8'h00);
        wr(1'b1, 1'b0, 8'h12);
        chk("R3 mode word", {6'd0, nest_special, auto_eoi}, 8'h03);
        chk("R3 mask held", mask_out, 8'h00);
        wr(1'b1, 1'b0, 8'h3C);
        chk("R4 mask after init", mask_out, 8'h3C);
        rd(1'b0, 1'b0);
        chk("R2 read select cleared", rdata, 8'h3C);
    endtask

    task automatic t_init_short();
        wr(1'b0, 1'b0, 8'h13);
        chk("R2 modes kept with fourth word", {6'd0, nest_special, auto_eoi}, 8'h03);
        wr(1'b1, 1'b0, 8'h08);
        wr(1'b1, 1'b0, 8'h00);
        wr(1'b1, 1'b0, 8'h12);
        wr(1'b0, 1'b0, 8'h10);
        chk("R2 modes cleared without fourth word", {6'd0, nest_special, auto_eoi}, 8'h00);
        wr(1'b1, 1'b0, 8'h20);
        chk("R3 vector base 2", vec_base, 8'h20);
        wr(1'b1, 1'b0, 8'hFF);
        chk("R3 skip word no mask", mask_out, 8'h00);
        wr(1'b1, 1'b0, 8'h81);
        chk("R3 back to run, mask", mask_out, 8'h81);
        chk("R3 modes untouched", {6'd0, nest_special, auto_eoi}, 8'h00);
    endtask

    task automatic t_ocw3();
        req_bits = 8'h3C; svc_bits = 8'hA5;
        wr(1'b0, 1'b0, 8'h0B);
        rd(1'b0, 1'b0);
        chk("R11 in-service read", rdata, 8'hA5);
        wr(1'b0, 1'b0, 8'h09);
        rd(1'b0, 1'b0);
        chk("R5 select held when bit1 clear", rdata, 8'hA5);
        wr(1'b0, 1'b0, 8'h0A);
        rd(1'b0, 1'b0);
        chk("R11 request read", rdata, 8'h3C);
        rd(1'b1, 1'b0);
        chk("R11 mask read", rdata, 8'h81);
        wr(1'b0, 1'b0, 8'h68);
        wr(1'b0, 1'b0, 8'h28);
        chk("R5 smm held when bit6 clear", {7'd0, special_mask}, 8'h01);
        wr(1'b0, 1'b0, 8'h48);
        chk("R5 smm cleared", {7'd0, special_mask}, 8'h00);
    endtask

    task automatic t_rae();
        wr(1'b0, 1'b0, 8'h80);
        chk("R6 code 4", {7'd0, rot_auto_eoi}, 8'h01);
        wr(1'b0, 1'b0, 8'h00);
        chk("R6 code 0", {7'd0, rot_auto_eoi}, 8'h00);
    endtask

    task automatic t_eoi();
        wr(1'b0, 1'b0, 8'hC7);
        chk("R9 rot wraps", {5'd0, rot_base}, 8'h00);
        svc_bits = 8'h24;
        wr(1'b0, 1'b0, 8'h20);
        chk("R7 nonspecific base 0", svc_clr, 8'h04);
        @(negedge clk);
        chk("R7 pulse one cycle", svc_clr, 8'h00);
        wr(1'b0, 1'b0, 8'hC2);
        wr(1'b0, 1'b0, 8'h20);
        chk("R7 nonspecific base 3", svc_clr, 8'h20);
        wr(1'b0, 1'b0, 8'hA0);
        chk("R7 rotating clear", svc_clr, 8'h20);
        chk("R7 rotating base", {5'd0, rot_base}, 8'h06);
        svc_bits = 8'h00;
        wr(1'b0, 1'b0, 8'h20);
        chk("R7 empty code 1", svc_clr, 8'h00);
        wr(1'b0, 1'b0, 8'hA0);
        chk("R7 empty code 5 clr", svc_clr, 8'h00);
        chk("R7 empty code 5 rot", {5'd0, rot_base}, 8'h06);
        wr(1'b0, 1'b0, 8'h66);
        chk("R8 specific clear", svc_clr, 8'h40);
        chk("R8 specific keeps rot", {5'd0, rot_base}, 8'h06);
        wr(1'b0, 1'b0, 8'hE1);
        chk("R8 specific rotate clear", svc_clr, 8'h02);
        chk("R8 specific rotate base", {5'd0, rot_base}, 8'h02);
        wr(1'b0, 1'b0, 8'h45);
        chk("R9 nop clr", svc_clr | req_clr, 8'h00);
        chk("R9 nop rot", {5'd0, rot_base}, 8'h02);
        chk("R9 nop mask", mask_out, 8'h81);
    endtask

    task automatic t_poll();
        req_bits = 8'h11; svc_bits = 8'h00;
        win_valid = 1'b1; win_line = 3'd5;
        wr(1'b0, 1'b0, 8'h0C);
        rd(1'b0, 1'b0);
        chk("R10 poll byte", rdata, 8'h85);
        chk("R10 poll svc clr", svc_clr, 8'h20);
        chk("R10 poll req clr", req_clr, 8'h20);
        rd(1'b0, 1'b0);
        chk("R10 poll one-shot", rdata, 8'h11);
        win_valid = 1'b0;
        wr(1'b0, 1'b0, 8'h0C);
        rd(1'b1, 1'b0);
        chk("R10 idle poll", rdata, 8'h07);
        chk("R10 idle no clr", svc_clr | req_clr, 8'h00);
        rd(1'b1, 1'b0);
        chk("R10 disarmed", rdata, 8'h81);
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_trig();
        t_running_setup();
        t_init_full();
        t_init_short();
        t_ocw3();
        t_rae();
        t_eoi();
        t_poll();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule